// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt events for a small 8-bit microcontroller core and turns them into one request and one vector number for the CPU. There are twelve sources: bus reset, several endpoint events, hub, DAC, two periodic timers, GPIO and I2C. Each source raises a one-cycle event pulse. The pulse is latched into a pending bit for that source. The pending bit is masked by a per-source enable bit. A fixed-priority encoder then picks the lowest-numbered enabled pending source.

A global enable bit gates the request that goes to the CPU. Separate strobes change this bit: enable, disable and return-from-interrupt. The CPU acknowledges at an instruction boundary. In that cycle the controller clears the global enable and the pending bit of the source being served, and the vector output names that source. A sense output stays high whenever an enabled request is pending, even while the global enable is off. Firmware can therefore poll for work with interrupts disabled.

Firmware sets the enables through a byte-wide register port. A read-only status byte reports the sense bit and the global enable bit.

Top module: `vicTop`

## Requirements
- R1: After reset, both enable registers read 0, the status byte reads 0, and irqOut, irqSense and gieOut are all low.
- R2: An event pulse on evtIn[i] sets the pending bit of source i. The bit stays set until an acknowledge that serves source i, or until reset.
- R3: Only pending sources that are enabled count as requests. Enables for sources 0..7 are bits 0..7 of the register at address 0x20. Enables for sources 8..11 are bits 0..3 of the register at address 0x21.
- R4: irqSense is high whenever at least one enabled source is pending, whatever the state of the global enable. The status register at address 0x22 shows irqSense in bit 7 and gieOut in bit 2, and its other bits read 0.
- R5: irqOut is high exactly when irqSense and gieOut are both high.
- R6: vecOut gives the index of the lowest-numbered enabled pending source. Source 0 has the highest priority and source 11 the lowest.
- R7: An acknowledge while irqOut is high does two things on the next clock edge. It clears gieOut, and it clears the pending bit of the source shown on vecOut. All other pending bits are kept.
- R8: An acknowledge while irqOut is low changes neither the pending state nor the global enable.
- R9: eiStb and retiStb set gieOut, and diStb clears it. None of them changes the pending bits or the enable registers.
- R10: If an event for a source arrives in the same cycle as the acknowledge that clears that source, the source stays pending.
- R11: While irqOut stays high from one cycle to the next with no acknowledge in between, vecOut keeps its value, even if a higher-priority source becomes pending.
- R12: In the register at address 0x21, bits above 3 read 0. Writes to addresses other than 0x20 and 0x21 change no state. This includes writes to the status address 0x22.
- R13: When a clearing condition and a setting strobe arrive in the same cycle, the clear wins. The clearing conditions are diStb and a taken acknowledge; the setting strobes are eiStb and retiStb.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtIn | input | 12 | One-cycle event pulses, one per source |
| regAddr | input | 8 | Register address |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| eiStb | input | 1 | Set global enable |
| diStb | input | 1 | Clear global enable |
| retiStb | input | 1 | Return from handler; sets global enable |
| ackIn | input | 1 | CPU acknowledge at an instruction boundary |
| irqOut | output | 1 | Interrupt request to the CPU |
| irqSense | output | 1 | An enabled source is pending, regardless of global enable |
| gieOut | output | 1 | Global interrupt enable state |
| vecOut | output | 4 | Index of the source being requested |

## Verification
The bench first sends each of the twelve sources alone with every enable set. This checks that every index reaches vecOut and that the acknowledge clears only that source. Next it raises every pair of sources in the same cycle. It checks that the lower index wins and that the higher one is still pending after the first acknowledge, which tells the priority order apart from any arrival order. A mask sweep raises all sources at once with a single enable bit set, which isolates the decoding of each enable bit. Directed cases cover four timing conflicts: an event in the acknowledge cycle, a higher-priority event while a request is held, an enable strobe in the same cycle as a disable, and an enable strobe in the same cycle as an acknowledge.

// File: rtl/vicPkg.sv
package vicPkg;
  localparam int NUM_SRC_DEF = 12;
  localparam int VEC_W_DEF   = 4;
  localparam int DATA_W_DEF  = 8;
  localparam int ADDR_W_DEF  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic ackTake;
    logic wrEnLo;
    logic wrEnHi;
  } vicStrb_t;
endpackage

// File: rtl/vicDatapath.sv
module vicDatapath
  import vicPkg::*;
#(
  parameter int NUM_SRC = NUM_SRC_DEF,
  parameter int VEC_W   = VEC_W_DEF,
  parameter int DATA_W  = DATA_W_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  vicStrb_t           strb,
  input  logic               irqIn,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] enMask,
  output logic               senseOut,
  output logic [VEC_W-1:0]   vecOut
);
  localparam int HI_W = NUM_SRC - DATA_W;

  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] hitVec;
  logic [VEC_W-1:0]   encVec;
  logic [VEC_W-1:0]   vecQ;
  logic               lockQ;

  assign hitVec   = pendQ & enQ;
  assign senseOut = |hitVec;
  assign enMask   = enQ;

  // fixed priority: lowest index wins
  always_comb begin
    encVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hitVec[i]) encVec = VEC_W'(i);
    end
  end

  // hold the vector while a request stays up
  assign vecOut = lockQ ? vecQ : encVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      vecQ  <= '0;
    end else begin
      lockQ <= irqIn && !strb.ackTake;
      vecQ  <= vecOut;
    end
  end

  // pending latches, one per source; new event beats the clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    logic clrHit;
    assign clrHit = strb.ackTake && (vecOut == VEC_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= evtIn[g] | (pendQ[g] & ~clrHit);
    end
  end

  // enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= '0;
    end else begin
      if (strb.wrEnLo) enQ[DATA_W-1:0]       <= wdata;
      if (strb.wrEnHi) enQ[NUM_SRC-1:DATA_W] <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/vicControl.sv
module vicControl
  import vicPkg::*;
#(
  parameter int NUM_SRC = NUM_SRC_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] EN_LO_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] EN_HI_ADDR = 8'h21,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic               eiStb,
  input  logic               diStb,
  input  logic               retiStb,
  input  logic               ackIn,
  input  logic               senseIn,
  input  logic [NUM_SRC-1:0] enMask,
  output vicStrb_t           strb,
  output logic               irqOut,
  output logic               gieOut,
  output logic [DATA_W-1:0]  rdata
);
  localparam int SENSE_BIT = DATA_W - 1;
  localparam int GIE_BIT   = 2;

  logic gieQ;

  assign gieOut = gieQ;
  assign irqOut = senseIn && gieQ;

  assign strb.ackTake = ackIn && irqOut;
  assign strb.wrEnLo  = regWr && (regAddr == EN_LO_ADDR);
  assign strb.wrEnHi  = regWr && (regAddr == EN_HI_ADDR);

  // clears take precedence over sets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           gieQ <= 1'b0;
    else if (strb.ackTake || diStb)      gieQ <= 1'b0;
    else if (eiStb || retiStb)           gieQ <= 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (regAddr == EN_LO_ADDR) begin
      rdata = enMask[DATA_W-1:0];
    end else if (regAddr == EN_HI_ADDR) begin
      rdata = DATA_W'(enMask[NUM_SRC-1:DATA_W]);
    end else if (regAddr == STAT_ADDR) begin
      rdata[SENSE_BIT] = senseIn;
      rdata[GIE_BIT]   = gieQ;
    end
  end
endmodule

// File: rtl/vicTop.sv
module vicTop
  import vicPkg::*;
#(
  parameter int NUM_SRC = NUM_SRC_DEF,
  parameter int VEC_W   = VEC_W_DEF,
  parameter int DATA_W  = DATA_W_DEF,
  parameter int ADDR_W  = ADDR_W_DEF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic               eiStb,
  input  logic               diStb,
  input  logic               retiStb,
  input  logic               ackIn,
  output logic               irqOut,
  output logic               irqSense,
  output logic               gieOut,
  output logic [VEC_W-1:0]   vecOut
);
  vicStrb_t           strb;
  logic [NUM_SRC-1:0] enMask;

  vicControl #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .eiStb(eiStb), .diStb(diStb), .retiStb(retiStb), .ackIn(ackIn),
    .senseIn(irqSense), .enMask(enMask), .strb(strb),
    .irqOut(irqOut), .gieOut(gieOut), .rdata(regRdata)
  );

  vicDatapath #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .strb(strb), .irqIn(irqOut),
    .wdata(regWdata), .enMask(enMask), .senseOut(irqSense), .vecOut(vecOut)
  );
endmodule

// File: rtl/vicChecker.sv
module vicChecker #(
  parameter int NUM_SRC = 12,
  parameter int VEC_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic             eiStb,
  input logic             diStb,
  input logic             retiStb,
  input logic             ackIn,
  input logic             irqOut,
  input logic             irqSense,
  input logic             gieOut,
  input logic [VEC_W-1:0] vecOut
);
  // R5
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (gieOut && irqSense));

  // R7
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irqOut) |=> !gieOut);

  // R9
  ei_sets_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((eiStb || retiStb) && !diStb && !(ackIn && irqOut)) |=> gieOut);

  // R9
  di_clears_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    diStb |=> !gieOut);

  // R2
  sense_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqSense && !ackIn && !regWr) |=> irqSense);

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackIn) |=> (!irqOut || $stable(vecOut)));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqSense |-> (vecOut < VEC_W'(NUM_SRC)));
endmodule

bind vicTop vicChecker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .eiStb(eiStb), .diStb(diStb),
  .retiStb(retiStb), .ackIn(ackIn), .irqOut(irqOut), .irqSense(irqSense),
  .gieOut(gieOut), .vecOut(vecOut)
);

// File: tb/sim_vicTop.sv
`timescale 1ns/1ps
module sim_vicTop;
  localparam int NS = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] evtIn = '0;
  logic [7:0]    regAddr = '0;
  logic          regWr = 1'b0;
  logic [7:0]    regWdata = '0;
  logic [7:0]    regRdata;
  logic          eiStb = 1'b0, diStb = 1'b0, retiStb = 1'b0, ackIn = 1'b0;
  logic          irqOut, irqSense, gieOut;
  logic [3:0]    vecOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vicTop u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .eiStb(eiStb), .diStb(diStb),
    .retiStb(retiStb), .ackIn(ackIn), .irqOut(irqOut), .irqSense(irqSense),
    .gieOut(gieOut), .vecOut(vecOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output int d);
    regAddr = a;
    #1;
    d = int'(regRdata);
  endtask

  task automatic setEn(input logic [NS-1:0] m);
    wrReg(8'h20, m[7:0]);
    wrReg(8'h21, {4'b0, m[11:8]});
  endtask

  task automatic pulseEvt(input logic [NS-1:0] m);
    evtIn = m; step(); evtIn = '0;
  endtask

  task automatic doEi();
    eiStb = 1'b1; step(); eiStb = 1'b0;
  endtask

  task automatic doAck();
    ackIn = 1'b1; step(); ackIn = 1'b0;
  endtask

  task automatic drain();
    setEn('1);
    for (int k = 0; k < NS + 1; k++) begin
      if (irqSense) begin doEi(); doAck(); end
    end
    diStb = 1'b1; step(); diStb = 1'b0;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : main
    int rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1 reset state
    rdReg(8'h20, rd); chk("R1 en lo", rd, 0);
    rdReg(8'h21, rd); chk("R1 en hi", rd, 0);
    rdReg(8'h22, rd); chk("R1 status", rd, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 sense", irqSense, 0);
    chk("R1 gie", gieOut, 0);

    // R3 masked event, then R2 pending retained until enable
    pulseEvt(12'h008);
    chk("R3 masked sense", irqSense, 0);
    setEn(12'h008);
    chk("R2 pending kept", irqSense, 1);
    chk("R6 vec 3", vecOut, 3);
    // R4 sense without gie
    chk("R4 irq low", irqOut, 0);
    rdReg(8'h22, rd); chk("R4 status sense", rd, 8'h80);
    // R9 EI / DI / RETI
    doEi();
    chk("R9 ei gie", gieOut, 1);
    chk("R5 irq high", irqOut, 1);
    rdReg(8'h22, rd); chk("R4 status both", rd, 8'h84);
    diStb = 1'b1; step(); diStb = 1'b0;
    chk("R9 di gie", gieOut, 0);
    chk("R9 di keeps pend", irqSense, 1);
    rdReg(8'h20, rd); chk("R9 di keeps en", rd, 8'h08);
    retiStb = 1'b1; step(); retiStb = 1'b0;
    chk("R9 reti gie", gieOut, 1);
    // R7 ack
    doAck();
    chk("R7 ack gie", gieOut, 0);
    chk("R7 ack clears", irqSense, 0);

    // R8 ack without irq ignored
    setEn('1);
    pulseEvt(12'h010);
    doAck();
    chk("R8 pend kept", irqSense, 1);
    chk("R8 vec", vecOut, 4);
    chk("R8 gie", gieOut, 0);
    drain();

    // R6/R7 single-source sweep
    for (int i = 0; i < NS; i++) begin
      pulseEvt(NS'(1) << i);
      doEi();
      chk("R5 single irq", irqOut, 1);
      chk("R6 single vec", vecOut, i);
      doAck();
      chk("R7 single clear", irqSense, 0);
      chk("R7 single gie", gieOut, 0);
    end

    // R6/R7 pair sweep: lower index first, higher remains
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        pulseEvt((NS'(1) << i) | (NS'(1) << j));
        doEi();
        chk("R6 pair first", vecOut, i);
        doAck();
        chk("R7 pair other kept", irqSense, 1);
        chk("R7 pair irq low", irqOut, 0);
        doEi();
        chk("R6 pair second", vecOut, j);
        doAck();
        chk("R7 pair done", irqSense, 0);
      end
    end

    // R3 mask sweep: one enable, all sources pending
    for (int k = 0; k < NS; k++) begin
      setEn(NS'(1) << k);
      pulseEvt('1);
      chk("R3 mask sense", irqSense, 1);
      chk("R3 mask vec", vecOut, k);
      drain();
      chk("R3 drained", irqSense, 0);
    end

    // R10 event during its own ack
    setEn('1);
    pulseEvt(12'h040);
    doEi();
    ackIn = 1'b1; evtIn = 12'h040; step(); ackIn = 1'b0; evtIn = '0;
    chk("R10 set wins", irqSense, 1);
    chk("R10 vec", vecOut, 6);
    chk("R10 gie", gieOut, 0);
    drain();

    // R11 vector held against higher-priority arrival
    pulseEvt(12'h020);
    doEi();
    chk("R11 vec before", vecOut, 5);
    pulseEvt(12'h004);
    chk("R11 irq still", irqOut, 1);
    chk("R11 vec held", vecOut, 5);
    doAck();
    chk("R11 after ack sense", irqSense, 1);
    chk("R11 after ack vec", vecOut, 2);
    doEi();
    chk("R11 new vec", vecOut, 2);
    doAck();
    chk("R11 drained", irqSense, 0);

    // R13 clear beats set
    eiStb = 1'b1; diStb = 1'b1; step(); eiStb = 1'b0; diStb = 1'b0;
    chk("R13 di over ei", gieOut, 0);
    pulseEvt(12'h002);
    doEi();
    ackIn = 1'b1; eiStb = 1'b1; step(); ackIn = 1'b0; eiStb = 1'b0;
    chk("R13 ack over ei", gieOut, 0);
    chk("R13 ack cleared", irqSense, 0);

    // R12 register map corners
    wrReg(8'h21, 8'hFF);
    rdReg(8'h21, rd); chk("R12 hi width", rd, 8'h0F);
    wrReg(8'h20, 8'hA5);
    wrReg(8'h23, 8'h00);
    wrReg(8'h22, 8'hFF);
    rdReg(8'h20, rd); chk("R12 stray lo", rd, 8'hA5);
    rdReg(8'h21, rd); chk("R12 stray hi", rd, 8'h0F);
    rdReg(8'h22, rd); chk("R12 status ro", rd, 0);
    chk("R12 gie ro", gieOut, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule